// File: doc/BRIEF.md
# Quadrature Octave Clock Divider

This block turns one fast oscillator clock into two square-wave local-oscillator signals, I and Q, a quarter period apart. Their frequency is the input clock divided by 2^n, with n chosen from 2 to 10. An oscillator between 60 and 120 MHz therefore covers outputs from roughly 58 kHz up to 30 MHz. The division has two parts. A binary prescaler divides by 2^(n-2) and produces a one-cycle step strobe. A two-flip-flop twisted-ring stage advances once per strobe. That stage always supplies the last factor of four, and it is what creates the 90 degree offset.

The exponent is loaded through a plain synchronous control port: a 4-bit code and a one-cycle load strobe. A loaded value is held pending and takes effect only when the prescaler wraps. That moment is also a quarter-period boundary, so no output level is cut short. After a reset, and after each applied exponent, a lock flag stays low for two full output periods at the new ratio. The block has no data stream, so every pin is a plain control or status signal and there is no back-pressure.

Top module: `quad_lo_divider`

## Requirements
- R1: With exponent n applied, lo_i and lo_q each repeat every 2^n input clock cycles.
- R2: lo_q rises exactly 2^(n-2) cycles after lo_i rises, so I leads Q by a quarter period. lo_i is high whenever lo_q rises. Together the pair steps through {I,Q} = 00, 10, 11, 01.
- R3: lo_i and lo_q are each high for exactly 2^(n-1) cycles of every period, which is a 50 percent duty cycle.
- R4: A load code below 2 is applied as 2, a code above 10 is applied as 10, and codes 2 to 10 are applied unchanged.
- R5: A loaded exponent takes effect only at a quarter-period step. No output level between a load and the following lock lasts fewer cycles than the smaller of the old and new quarter periods.
- R6: While rst is high, lo_i, lo_q and lo_lock are low. After reset the exponent is 2, which gives a divide-by-4.
- R7: lo_lock falls in the cycle after an exponent is applied. After a reset or an apply it stays low for exactly 2^(n+1) cycles, which is two output periods at the new ratio, and then rises.
- R8: If several loads arrive before the next quarter step, only the last one is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | One-cycle strobe that captures cfg_exp as the pending exponent |
| cfg_exp | input | 4 | Requested divide exponent n (ratio 2^n), clamped to 2..10 |
| lo_i | output | 1 | In-phase local-oscillator output |
| lo_q | output | 1 | Quadrature output, a quarter period behind lo_i |
| lo_lock | output | 1 | High once two full periods have elapsed at the current ratio |

## Verification
A load is applied on the first quarter step that follows it, and lo_lock drops one cycle later. The bench therefore does not predict the apply cycle. It waits for lo_lock to fall and then counts low cycles sampled at the falling clock edge, expecting exactly 2^(n+1). Period, quarter offset and high time are measured only once lock is high. Each of them is counted in whole cycles from a rising edge of lo_i seen at the falling edge: 2^n cycles to the next rise of lo_i, 2^(n-2) cycles to the rise of lo_q, and 2^(n-1) cycles to the fall of lo_i. The double-load case is issued just after a visible output step at a ratio of 1024, so that both loads land in the same quarter.

// File: rtl/qld_pkg.sv
package qld_pkg;

  // Smallest exponent: the twisted-ring stage alone divides by four.
  localparam int unsigned QLD_MIN_EXP = 2;

  // Output phase register, bit 1 = I, bit 0 = Q.
  typedef enum logic [1:0] {
    QP_LOW  = 2'b00,
    QP_I    = 2'b10,
    QP_BOTH = 2'b11,
    QP_Q    = 2'b01
  } qld_phase_e;

  function automatic int unsigned qld_clamp(input int unsigned code,
                                            input int unsigned hi);
    if (code < QLD_MIN_EXP) return QLD_MIN_EXP;
    if (code > hi)          return hi;
    return code;
  endfunction

endpackage

// File: rtl/qld_exp_ctrl.sv
module qld_exp_ctrl
  import qld_pkg::*;
#(
  parameter int unsigned EXPW      = 4,
  parameter int unsigned MAX_EXP   = 10,
  parameter int unsigned RESET_EXP = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [EXPW-1:0] code,
  input  logic            tick,
  output logic [EXPW-1:0] act_exp,
  output logic            apply
);

  logic [EXPW-1:0] clamped;
  logic [EXPW-1:0] pend_exp;
  logic            pend_vld;

  assign clamped = EXPW'(qld_clamp(int'(code), MAX_EXP));
  assign apply   = tick & pend_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_exp  <= EXPW'(RESET_EXP);
      pend_exp <= EXPW'(RESET_EXP);
      pend_vld <= 1'b0;
    end else begin
      if (apply) act_exp <= pend_exp;
      if (load) begin
        pend_exp <= clamped;
        pend_vld <= 1'b1;
      end else if (tick) begin
        pend_vld <= 1'b0;
      end
    end
  end

  // R4: the applied exponent always lies in the legal range
  a_r4_exp_legal: assert property (@(posedge clk) disable iff (rst)
    (act_exp >= EXPW'(QLD_MIN_EXP)) && (act_exp <= EXPW'(MAX_EXP)));

  // R5: the ratio only changes on a prescaler wrap
  a_r5_change_on_wrap: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(act_exp));

endmodule

// File: rtl/qld_prescaler.sv
module qld_prescaler
  import qld_pkg::*;
#(
  parameter int unsigned EXPW    = 4,
  parameter int unsigned MAX_EXP = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [EXPW-1:0] act_exp,
  output logic            tick
);

  localparam int unsigned PW = MAX_EXP - QLD_MIN_EXP;

  logic [PW-1:0] cnt;
  logic [PW-1:0] limit;

  always_comb begin
    int unsigned sh;
    sh    = int'(act_exp) - QLD_MIN_EXP;
    limit = PW'((32'd1 << sh) - 32'd1);
  end

  assign tick = (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  // R1: the count never passes the terminal value of the active ratio
  a_r1_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= limit);

endmodule

// File: rtl/qld_quad.sv
module qld_quad
  import qld_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output logic lo_i,
  output logic lo_q
);

  qld_phase_e ph;
  qld_phase_e ph_nx;

  always_comb begin
    unique case (ph)
      QP_LOW:  ph_nx = QP_I;
      QP_I:    ph_nx = QP_BOTH;
      QP_BOTH: ph_nx = QP_Q;
      default: ph_nx = QP_LOW;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)       ph <= QP_LOW;
    else if (tick) ph <= ph_nx;
  end

  assign lo_i = ph[1];
  assign lo_q = ph[0];

  // R2: only one output toggles per step
  a_r2_single_toggle: assert property (@(posedge clk) disable iff (rst)
    $countones(ph ^ $past(ph)) <= 1);

  // R2: Q only rises while I is high
  a_r2_i_leads_q: assert property (@(posedge clk) disable iff (rst)
    $rose(lo_q) |-> lo_i);

  // R5: outputs hold between prescaler strobes
  a_r5_hold_between: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(ph));

endmodule

// File: rtl/qld_lock.sv
module qld_lock #(
  parameter int unsigned LOCK_STEPS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic tick,
  output logic locked
);

  localparam int unsigned CW = $clog2(LOCK_STEPS + 1);

  logic [CW-1:0] steps;

  always_ff @(posedge clk) begin
    if (rst || restart)                           steps <= '0;
    else if (tick && (steps != CW'(LOCK_STEPS)))  steps <= steps + 1'b1;
  end

  assign locked = (steps == CW'(LOCK_STEPS));

  // R7: lock only drops because a new ratio was applied
  a_r7_fall_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> $past(restart));

  // R7: lock is low right after an apply
  a_r7_low_after: assert property (@(posedge clk) disable iff (rst)
    restart |=> !locked);

endmodule

// File: rtl/quad_lo_divider.sv
module quad_lo_divider
  import qld_pkg::*;
#(
  parameter int unsigned EXPW         = 4,
  parameter int unsigned MAX_EXP      = 10,
  parameter int unsigned RESET_EXP    = 2,
  parameter int unsigned LOCK_PERIODS = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_load,
  input  logic [EXPW-1:0] cfg_exp,
  output logic            lo_i,
  output logic            lo_q,
  output logic            lo_lock
);

  localparam int unsigned LOCK_STEPS = 4 * LOCK_PERIODS;

  logic [EXPW-1:0] act_exp;
  logic            apply;
  logic            tick;

  qld_exp_ctrl #(.EXPW(EXPW), .MAX_EXP(MAX_EXP), .RESET_EXP(RESET_EXP)) u_ctrl (
    .clk(clk), .rst(rst), .load(cfg_load), .code(cfg_exp), .tick(tick),
    .act_exp(act_exp), .apply(apply)
  );

  qld_prescaler #(.EXPW(EXPW), .MAX_EXP(MAX_EXP)) u_pre (
    .clk(clk), .rst(rst), .act_exp(act_exp), .tick(tick)
  );

  qld_quad u_quad (
    .clk(clk), .rst(rst), .tick(tick), .lo_i(lo_i), .lo_q(lo_q)
  );

  qld_lock #(.LOCK_STEPS(LOCK_STEPS)) u_lock (
    .clk(clk), .rst(rst), .restart(apply), .tick(tick), .locked(lo_lock)
  );

  // R6: everything is low in the cycle after a reset edge
  a_r6_reset_low: assert property (@(posedge clk)
    $past(rst) |-> (!lo_i && !lo_q && !lo_lock));

endmodule

// File: tb/sim_quad_lo_divider.sv
module sim_quad_lo_divider;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_load = 1'b0;
  logic [3:0] cfg_exp = 4'd0;
  logic       lo_i, lo_q, lo_lock;

  int checks = 0;
  int failures = 0;
  int cur_n = 2;
  int seg_len = 0;
  int seg_min = 1 << 20;
  logic [1:0] prev_iq = 2'b00;

  always #5 clk = ~clk;

  quad_lo_divider u0 (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_exp(cfg_exp),
    .lo_i(lo_i), .lo_q(lo_q), .lo_lock(lo_lock)
  );

  function automatic int exp_of(input int code);
    if (code < 2)  return 2;
    if (code > 10) return 10;
    return code;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Output segment monitor for R5
  always @(negedge clk) begin
    if (rst) begin
      seg_len = 0;
      prev_iq = 2'b00;
    end else begin
      if ({lo_i, lo_q} != prev_iq) begin
        if (seg_len < seg_min) seg_min = seg_len;
        seg_len = 1;
      end else begin
        seg_len++;
      end
      prev_iq = {lo_i, lo_q};
    end
  end

  // Cycles of lock-low after a fall, checked against two periods (R7)
  task automatic lock_window(input int n, input string tag);
    int cnt;
    while (lo_lock) @(negedge clk);
    cnt = 0;
    while (!lo_lock) begin
      cnt++;
      @(negedge clk);
    end
    chk(cnt == (1 << (n + 1)), {tag, " R7 lock window"}, cnt, 1 << (n + 1));
  endtask

  // Period (R1), quarter offset (R2), high time (R3)
  task automatic measure(input int n, input string tag);
    int t, tq, tf, tp;
    logic pi, pq;
    pi = lo_i;
    while (!(lo_i && !pi)) begin
      pi = lo_i;
      @(negedge clk);
    end
    t = 0; tq = -1; tf = -1; tp = -1;
    pi = 1'b1; pq = lo_q;
    while (tp < 0) begin
      @(negedge clk);
      t++;
      if (lo_q && !pq && tq < 0) tq = t;
      if (!lo_i && pi && tf < 0) tf = t;
      if (lo_i && !pi) tp = t;
      pi = lo_i;
      pq = lo_q;
    end
    chk(tp == (1 << n), {tag, " R1 period"}, tp, 1 << n);
    chk(tq == (1 << (n - 2)), {tag, " R2 I-to-Q offset"}, tq, 1 << (n - 2));
    chk(tf == (1 << (n - 1)), {tag, " R3 high time"}, tf, 1 << (n - 1));
  endtask

  task automatic load_code(input int code, input string tag);
    int n_new, lim;
    n_new = exp_of(code);
    @(negedge clk);
    cfg_exp = 4'(code);
    cfg_load = 1'b1;
    seg_min = 1 << 20;
    @(negedge clk);
    cfg_load = 1'b0;
    lim = (n_new < cur_n) ? (1 << (n_new - 2)) : (1 << (cur_n - 2));
    lock_window(n_new, tag);
    chk(seg_min >= lim, {tag, " R5 no short level"}, seg_min, lim);
    cur_n = n_new;
    measure(n_new, tag);
  endtask

  initial begin
    int k;
    repeat (3) @(negedge clk);
    chk(!lo_i && !lo_q && !lo_lock, "R6 outputs low in reset",
        int'({lo_i, lo_q, lo_lock}), 0);
    rst = 1'b0;
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!lo_lock && k < 100);
    chk(k == 8, "R6 R7 lock after reset at divide-by-4", k, 8);
    measure(2, "reset ratio R6");

    for (int n = 2; n <= 10; n++) load_code(n, "directed");

    load_code(0, "R4 code 0");
    chk(cur_n == 2, "R4 clamp low", cur_n, 2);
    load_code(15, "R4 code 15");
    load_code(1, "R4 code 1");
    load_code(11, "R4 code 11");

    // R8: two loads within one quarter at ratio 1024; the last one wins
    load_code(10, "R8 setup");
    begin
      logic p;
      p = lo_i;
      @(negedge clk);
      while (lo_i == p) @(negedge clk);
    end
    cfg_exp = 4'd3;
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_exp = 4'd5;
    @(negedge clk);
    cfg_load = 1'b0;
    lock_window(5, "R8 last write");
    cur_n = 5;
    measure(5, "R8 last write");

    void'($urandom(32'd1234));
    for (int r = 0; r < 6; r++) load_code(int'($urandom_range(0, 15)), "random");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule